// File: doc/BRIEF.md
# Paired Moore State Machines (Six-State and Reduced)

This block holds two Moore state machines that answer to one 1-bit input `x_in` and each drive a 1-bit output. The first follows a fixed six-state transition table with no simplification. The second has the same table after state minimisation, which leaves four states. Both run from one clock and one active-high synchronous reset. Because the output of each depends only on its present state, the two must give the same output sequence for every input sequence.

The pair is meant as a checked reference. The six-state machine states the behaviour in its plain form. The reduced machine is the cheaper one to build. Both outputs come out at the top so that logic around the block, or a bench, can compare them cycle by cycle.

The input and outputs are plain control bits. There is no stream traffic, so there is no valid/ready handshake.

Top module: `moore_pair_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, both machines enter state 0. After that edge, both `y_full` and `y_min` read 0.
- R2: In state 0 the output is 0. The next state is 1 when `x_in`=0 and 2 when `x_in`=1.
- R3: In state 1 the output is 1. The next state is 1 when `x_in`=0 and 3 when `x_in`=1.
- R4: In state 2 the output is 1. The next state is 2 when `x_in`=0 and 4 when `x_in`=1.
- R5: In state 3 and in state 4 the output is 0. From either state, the next state is 5 when `x_in`=0 and 0 when `x_in`=1.
- R6: In state 5 the output is 1. The next state is 0 for either value of `x_in`.
- R7: The reduced machine has four states, one for each class: {0}, {1,2}, {3,4} and {5}. Its output `y_min` equals `y_full` in every cycle after reset, for any input sequence.
- R8: Reset has priority over `x_in`. While `rst` stays high, toggling `x_in` leaves both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Machine input, sampled each rising edge |
| y_full | output | 1 | Moore output of the six-state machine |
| y_min | output | 1 | Moore output of the reduced four-state machine |

## Verification
The assertions assume two things. First, `rst` is high at the first rising edge. Second, `x_in` is always 0 or 1 and never unknown, since the transition checks and the equality check read it directly. The bench holds reset from time zero and drives `x_in` only with 0 or 1, always at the falling edge. Every input sequence of length eight is swept from a fresh reset. A long pseudo-random run follows, which reaches states 3, 4 and 5 along every path into them.

// File: rtl/moore_pair_pkg.sv
package moore_pair_pkg;

  // Six-state machine: binary state numbers 0..5; codes 6 and 7 are unused.
  typedef enum logic [2:0] {
    FS0 = 3'd0,
    FS1 = 3'd1,
    FS2 = 3'd2,
    FS3 = 3'd3,
    FS4 = 3'd4,
    FS5 = 3'd5
  } full_state_t;

  // Reduced machine: one code per equivalence class.
  typedef enum logic [1:0] {
    RS_START = 2'd0,  // {0}
    RS_HIGH  = 2'd1,  // {1,2}
    RS_LOW   = 2'd2,  // {3,4}
    RS_LAST  = 2'd3   // {5}
  } red_state_t;

endpackage

// File: rtl/moore_full.sv
module moore_full
  import moore_pair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic y_out
);

  full_state_t state_q, state_d;

  // Next-state logic, written straight from the table.
  always_comb begin
    state_d = FS0;
    unique case (state_q)
      FS0: state_d = x_in ? FS2 : FS1;
      FS1: state_d = x_in ? FS3 : FS1;
      FS2: state_d = x_in ? FS4 : FS2;
      FS3: state_d = x_in ? FS0 : FS5;
      FS4: state_d = x_in ? FS0 : FS5;
      FS5: state_d = FS0;
      default: state_d = FS0;  // unused codes fall back to state 0
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= FS0;
    else     state_q <= state_d;
  end

  // Moore output decode.
  always_comb begin
    unique case (state_q)
      FS1, FS2, FS5: y_out = 1'b1;
      default:       y_out = 1'b0;
    endcase
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> state_q == FS0);
  assert_s0_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == FS0 |=> (state_q == FS1 || state_q == FS2));
  assert_s1_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS1 && !x_in) |=> state_q == FS1);
  assert_s2_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS2 && x_in) |=> state_q == FS4);
  assert_s34_R5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == FS3 || state_q == FS4) && !x_in) |=> state_q == FS5);
  assert_s5_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == FS5 |=> state_q == FS0);

endmodule

// File: rtl/moore_min.sv
module moore_min
  import moore_pair_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic y_out
);

  red_state_t state_q, state_d;

  // Next-state logic over the equivalence classes.
  always_comb begin
    state_d = RS_START;
    unique case (state_q)
      RS_START: state_d = RS_HIGH;
      RS_HIGH:  state_d = x_in ? RS_LOW : RS_HIGH;
      RS_LOW:   state_d = x_in ? RS_START : RS_LAST;
      RS_LAST:  state_d = RS_START;
      default:  state_d = RS_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= RS_START;
    else     state_q <= state_d;
  end

  // Output is 1 in the {1,2} and {5} classes.
  assign y_out = (state_q == RS_HIGH) || (state_q == RS_LAST);

  assert_min_reset_R1: assert property (@(posedge clk) rst |=> state_q == RS_START);
  assert_min_low_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == RS_LOW && x_in) |=> state_q == RS_START);
  assert_min_last_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == RS_LAST |=> state_q == RS_START);

endmodule

// File: rtl/moore_pair_top.sv
module moore_pair_top (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic y_full,
  output logic y_min
);

  moore_full u_full (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .y_out (y_full)
  );

  moore_min u_min (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .y_out (y_min)
  );

  assert_outputs_match_R7: assert property (@(posedge clk) disable iff (rst)
    y_full == y_min);
  assert_reset_wins_R8: assert property (@(posedge clk)
    rst |=> (!y_full && !y_min));

endmodule

// File: tb/tb_moore_pair_top.sv
module tb_moore_pair_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic y_full, y_min;
  int   n_checks = 0;
  int   n_errors = 0;
  int   ref_st   = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  moore_pair_top dut (
    .clk    (clk),
    .rst    (rst),
    .x_in   (x_in),
    .y_full (y_full),
    .y_min  (y_min)
  );

  // Reference table, taken from the requirements R2 to R6.
  function automatic int next_of(int s, bit x);
    case (s)
      0: return x ? 2 : 1;
      1: return x ? 3 : 1;
      2: return x ? 4 : 2;
      3, 4: return x ? 0 : 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit out_of(int s);
    return (s == 1 || s == 2 || s == 5);
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit act, bit exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive x, clock once, check at the next falling edge.
  task automatic step(bit xv);
    x_in = xv;
    @(posedge clk);
    ref_st = rst ? 0 : next_of(ref_st, xv);
    @(negedge clk);
    if (rst) begin
      check(y_full, 1'b0, "R8 full");
      check(y_min,  1'b0, "R8 min");
    end else begin
      check(y_full, out_of(ref_st), tag_of(ref_st));
      check(y_min, y_full, "R7");
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0);
    rst = 1'b0;
    ref_st = 0;
    check(y_full, 1'b0, "R1 full");
    check(y_min,  1'b0, "R1 min");
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        do_reset();
        // R8: toggle x while reset is held.
        rst = 1'b1;
        for (int i = 0; i < 6; i++) step(i[0]);
        do_reset();
        // Exhaustive sweep: every 8-bit input sequence from a fresh reset.
        for (int pat = 0; pat < 256; pat++) begin
          do_reset();
          for (int b = 0; b < 8; b++) step(pat[b]);
        end
        // Long pseudo-random run.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          step(lfsr[0]);
        end
      end
      begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule